// File: doc/BRIEF.md
# ECC Chunk Status Aggregator

This block collects the per-chunk status codes that an ECC decoder reports while a page is read. Each code arrives as one byte on a valid-qualified stream. The block sorts every code into one of four classes: clean, erased, corrected or uncorrectable. From those classes it keeps page-level results: the sum of corrected bits, the largest corrected count seen in any one chunk, the number of uncorrectable chunks and a page failure flag.

A controller pulses `start` before the first chunk of a page. It then streams the status bytes and marks the final byte with `stat_last`. One cycle after that byte is taken, `done` pulses and the aggregates are final. `page_result` gives a single summary. It is an error code when any chunk failed; otherwise it is the worst corrected count. The results hold until the next `start`.

Top module: `ecc_page_tally`

## Requirements
- R1: After reset, tot_fix, max_fix, fail_cnt, page_fail and done are all zero.
- R2: A start pulse clears all accumulators at the next clock edge. A status byte presented in the same cycle as start is discarded.
- R3: Code 0x00 changes nothing. A byte with stat_valid low changes nothing, whatever its value.
- R4: Code 0xFF (erased) changes neither the corrected total, the maximum nor the failure count.
- R5: A code from 1 to 40 is added to tot_fix. max_fix takes the code when it exceeds the current maximum, so max_fix never exceeds 40.
- R6: Code 0xFE, and every code from 41 to 253, increments fail_cnt and sets page_fail. Such a code leaves tot_fix and max_fix unchanged.
- R7: page_result is 0xFF while page_fail is set. Otherwise it equals max_fix.
- R8: done is high for exactly the one cycle that follows the clock edge at which a valid byte with stat_last was taken. It is not raised after a byte that start discarded.
- R9: tot_fix saturates at 2^TOTAL_W-1 (1023 by default) rather than wrapping.
- R10: fail_cnt saturates at its all-ones value (31 by default) rather than wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Clears accumulators for a new page |
| stat_valid | input | 1 | Status byte qualifier |
| stat_code | input | 8 | Per-chunk ECC status code |
| stat_last | input | 1 | Marks the final chunk of the page |
| tot_fix | output | TOTAL_W | Saturating sum of corrected bits |
| max_fix | output | 8 | Largest per-chunk corrected count |
| fail_cnt | output | FAIL_W | Saturating count of uncorrectable chunks |
| page_fail | output | 1 | At least one chunk was uncorrectable |
| page_result | output | 8 | 0xFF on failure, otherwise max_fix |
| done | output | 1 | One-cycle pulse after the last chunk |

## Verification
Every accumulator is a visible output, and each one is registered one edge after its input. A misclassified code or a bad accumulator update therefore shows up on the ports in the cycle right after the byte is accepted. The bench compares all six outputs against its model on every clock, so a divergence is reported at the exact chunk that caused it. Boundary codes 40, 41, 0xFD, 0xFE and 0xFF, as well as long runs that drive both counters into saturation, expose errors that typical pages would hide.

// File: rtl/ecc_page_tally.sv
module ecc_page_tally #(
  parameter int          MAX_CHUNKS  = 16,
  parameter int          STRENGTH    = 40,
  parameter int          TOTAL_W     = 10,
  parameter logic [7:0]  ERASED_CODE = 8'hFF,
  parameter logic [7:0]  UNCORR_CODE = 8'hFE,
  parameter logic [7:0]  FAIL_RESULT = 8'hFF,
  localparam int         FAIL_W      = $clog2(MAX_CHUNKS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               stat_valid,
  input  logic [7:0]         stat_code,
  input  logic               stat_last,
  output logic [TOTAL_W-1:0] tot_fix,
  output logic [7:0]         max_fix,
  output logic [FAIL_W-1:0]  fail_cnt,
  output logic               page_fail,
  output logic [7:0]         page_result,
  output logic               done
);

  localparam logic [TOTAL_W-1:0] TOT_TOP  = '1;
  localparam logic [FAIL_W-1:0]  FAIL_TOP = '1;
  localparam logic [7:0]         CEIL     = 8'(STRENGTH);

  logic             take, is_erased, is_bad, is_fix;
  logic [TOTAL_W:0] tot_sum;

  assign take      = stat_valid && !start;
  assign is_erased = (stat_code == ERASED_CODE);
  assign is_bad    = !is_erased && ((stat_code == UNCORR_CODE) || (stat_code > CEIL));
  assign is_fix    = !is_erased && !is_bad && (stat_code != 8'd0);
  assign tot_sum   = {1'b0, tot_fix} + (TOTAL_W+1)'(stat_code);

  assign page_result = page_fail ? FAIL_RESULT : max_fix;

  always_ff @(posedge clk) begin
    if (!rst_n || start) begin
      tot_fix   <= '0;
      max_fix   <= '0;
      fail_cnt  <= '0;
      page_fail <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= take && stat_last;
      if (take && is_fix) begin
        tot_fix <= tot_sum[TOTAL_W] ? TOT_TOP : tot_sum[TOTAL_W-1:0];
        if (stat_code > max_fix) max_fix <= stat_code;
      end
      if (take && is_bad) begin
        if (fail_cnt != FAIL_TOP) fail_cnt <= fail_cnt + 1'b1;
        page_fail <= 1'b1;
      end
    end
  end

  logic armed;
  always_ff @(posedge clk) armed <= rst_n;

  AST_CLEAR_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(start) |-> (tot_fix == '0 && max_fix == '0 && fail_cnt == '0 && !page_fail && !done)); // R2
  AST_MAX_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    max_fix <= CEIL); // R5
  AST_FAIL_FLAG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    page_fail == (fail_cnt != '0)); // R6
  AST_DONE_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> done == $past(stat_valid && stat_last && !start)); // R8
  AST_TOTAL_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !$past(start) |-> tot_fix >= $past(tot_fix)); // R9
  AST_FAIL_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !$past(start) |-> fail_cnt >= $past(fail_cnt)); // R10

endmodule

// File: tb/ecc_page_tally_test.sv
module ecc_page_tally_test;
  localparam int TOT_MAX  = 1023;
  localparam int FAIL_MAX = 31;

  logic clk = 0, rst_n = 0, start = 0, stat_valid = 0, stat_last = 0;
  logic [7:0] stat_code = 0;
  logic [9:0] tot_fix;
  logic [7:0] max_fix, page_result;
  logic [4:0] fail_cnt;
  logic page_fail, done;

  int checks = 0, failures = 0;
  int m_tot = 0, m_max = 0, m_fail = 0, m_pf = 0, m_done = 0;

  always #10 clk = ~clk;

  ecc_page_tally uut (.clk, .rst_n, .start, .stat_valid, .stat_code, .stat_last,
    .tot_fix, .max_fix, .fail_cnt, .page_fail, .page_result, .done);

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare(input string req);
    check(req, "tot_fix", int'(tot_fix), m_tot);
    check(req, "max_fix", int'(max_fix), m_max);
    check(req, "fail_cnt", int'(fail_cnt), m_fail);
    check(req, "page_fail", int'(page_fail), m_pf);
    check("R7", "page_result", int'(page_result), m_pf ? 255 : m_max);
    check("R8", "done", int'(done), m_done);
  endtask

  task automatic step(input bit s, input bit v, input int c, input bit l, input string req);
    start = s; stat_valid = v; stat_code = 8'(c); stat_last = l;
    @(posedge clk);
    if (s) begin
      m_tot = 0; m_max = 0; m_fail = 0; m_pf = 0; m_done = 0;
    end else begin
      m_done = v && l;
      if (v && c != 255) begin
        if (c == 254 || c > 40) begin
          if (m_fail < FAIL_MAX) m_fail++;
          m_pf = 1;
        end else if (c != 0) begin
          m_tot = (m_tot + c > TOT_MAX) ? TOT_MAX : m_tot + c;
          if (c > m_max) m_max = c;
        end
      end
    end
    @(negedge clk);
    start = 0; stat_valid = 0; stat_last = 0;
    compare(req);
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1;
    step(1, 0, 0, 0, "R2");
    step(0, 1, 0, 0, "R3");
    step(0, 1, 3, 0, "R5");
    step(0, 1, 255, 0, "R4");
    step(0, 1, 7, 0, "R5");
    step(0, 1, 2, 0, "R5");
    step(0, 0, 30, 1, "R3");
    step(0, 1, 0, 1, "R8");
    step(0, 0, 0, 0, "R8");
    step(1, 0, 0, 0, "R2");
    step(0, 1, 40, 0, "R5");
    step(0, 1, 41, 0, "R6");
    step(0, 1, 254, 0, "R6");
    step(0, 1, 253, 0, "R6");
    step(0, 1, 255, 0, "R4");
    step(0, 1, 12, 1, "R7");
    step(1, 1, 5, 1, "R2");
    step(0, 0, 0, 0, "R2");
    step(0, 1, 9, 0, "R5");
    step(1, 1, 20, 0, "R2");
    for (int i = 0; i < 30; i++) step(0, 1, 40, i == 29, "R9");
    step(0, 1, 1, 0, "R9");
    step(1, 0, 0, 0, "R2");
    for (int i = 0; i < 35; i++) step(0, 1, (i % 2) ? 254 : 100, 0, "R10");
    step(0, 1, 6, 1, "R7");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule